// File: doc/BRIEF.md
# Vector lane insert with zero mask

This block is a registered datapath unit for a vector pipeline. It takes a first operand of four 32-bit lanes and a 32-bit value. That value is either one lane of a second four-lane operand or a scalar loaded from memory. The block writes the value into one chosen lane of the first operand. It then clears any lanes named by a per-lane zero mask. All three choices are packed into one 8-bit control byte. Lane values are raw 32-bit patterns. Nothing is interpreted as floating point, and no arithmetic exception can arise.

The destination register is wider than 128 bits. A parameter sets its full width. The bits above 128 are handled in one of two modes. Legacy mode passes in the caller's present upper bits, and they come back unchanged. Extended mode writes them as zero. In extended mode, a set vector-length bit is an illegal encoding. The block then raises an illegal flag for one cycle instead of performing the operation, and the destination is left untouched. Each request is accepted in one cycle and answered exactly one cycle later. There is no back-pressure.

Top module: `vins_lane_insert`

## Requirements
- R1: The control byte is decoded as follows: bits [7:6] give the source lane, bits [5:4] give the destination lane and bits [3:0] give the zero mask. Lane n occupies bits [32n+31:32n] of a 128-bit vector.
- R2: For a legal request from a register source, result lane dstLane equals lane srcLane of opB. The other three low lanes equal the matching lanes of opA, unless the zero mask clears them.
- R3: When srcIsMem is 1, memScalar is the inserted value, and control bits [7:6] have no effect on the result.
- R4: The zero mask acts after the insert. Each set mask bit i makes result lane i equal 32'h0, including when lane i is the destination lane.
- R5: In legacy mode (extMode=0), dest bits [MAX_VL-1:128] equal upperIn, and vecLenBit has no effect.
- R6: In extended mode (extMode=1) with vecLenBit=0, dest bits [MAX_VL-1:128] are written as zero.
- R7: A request with extMode=1 and vecLenBit=1 raises illegal together with outValid one cycle later, and dest keeps its previous value.
- R8: outValid is 1 exactly in the cycle after a cycle with inValid=1, and 0 otherwise. illegal is never 1 without outValid. dest changes only in the cycle after a legal request.
- R9: A synchronous active-high reset sets outValid and illegal to 0 and dest to all zeros.
- R10: Lane values move as exact bit patterns. NaN and denormal encodings are passed unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| inValid | input | 1 | Request strobe; inputs are sampled when high |
| ctrlByte | input | 8 | Source lane, destination lane and zero mask |
| srcIsMem | input | 1 | 1: insert memScalar; 0: insert a lane of opB |
| extMode | input | 1 | 0: legacy, keep upper bits; 1: extended, zero upper bits |
| vecLenBit | input | 1 | Vector-length bit; illegal when 1 in extended mode |
| opA | input | 128 | First operand, four 32-bit lanes |
| opB | input | 128 | Second operand, register source |
| memScalar | input | 32 | Scalar value, memory source |
| upperIn | input | MAX_VL-128 | Current upper destination bits for legacy mode |
| outValid | output | 1 | Result strobe, one cycle after inValid |
| illegal | output | 1 | Illegal encoding, qualified by outValid |
| dest | output | MAX_VL | Destination register value |

## Verification
Two functions can act on the same lane in one cycle: the insert and the zero mask. The bench provokes this with requests whose mask bit matches the destination lane, so the freshly inserted value must read back as zero while the unmasked lanes still carry opA. The bench also issues an illegal request right after a legal one. It expects the illegal flag and outValid in the same cycle, with dest still holding the earlier legal result. Every expected result comes from an independent lane model in the bench.

// File: rtl/vins_pkg.sv
package vins_pkg;
  localparam int LANE_W    = 32;
  localparam int NUM_LANES = 4;
  localparam int VEC_W     = LANE_W * NUM_LANES;
  localparam int IDX_W     = $clog2(NUM_LANES);
  localparam int CTRL_W    = 8;
  // Field positions inside the control byte
  localparam int SRC_LSB   = 6;
  localparam int DST_LSB   = 4;
  localparam int MASK_LSB  = 0;

  typedef struct packed {
    logic                 load;
    logic                 fromMem;
    logic                 zeroUpper;
    logic [IDX_W-1:0]     srcLane;
    logic [IDX_W-1:0]     dstLane;
    logic [NUM_LANES-1:0] zeroMask;
  } dpStrobe_t;
endpackage

// File: rtl/vins_ctrl.sv
module vins_ctrl
  import vins_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              inValid,
  input  logic [CTRL_W-1:0] ctrlByte,
  input  logic              srcIsMem,
  input  logic              extMode,
  input  logic              vecLenBit,
  output dpStrobe_t         strobe,
  output logic              outValid,
  output logic              illegal
);
  logic badLength;

  // The length bit only means something in extended mode
  assign badLength = extMode & vecLenBit;

  always_comb begin
    strobe           = '0;
    strobe.load      = inValid & ~badLength;
    strobe.fromMem   = srcIsMem;
    strobe.zeroUpper = extMode;
    strobe.srcLane   = srcIsMem ? '0 : ctrlByte[SRC_LSB +: IDX_W];
    strobe.dstLane   = ctrlByte[DST_LSB +: IDX_W];
    strobe.zeroMask  = ctrlByte[MASK_LSB +: NUM_LANES];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      outValid <= 1'b0;
      illegal  <= 1'b0;
    end else begin
      outValid <= inValid;
      illegal  <= inValid & badLength;
    end
  end
endmodule

// File: rtl/vins_dp.sv
module vins_dp
  import vins_pkg::*;
#(
  parameter int MAX_VL = 256
) (
  input  logic               clk,
  input  logic               rst,
  input  dpStrobe_t          strobe,
  input  logic [VEC_W-1:0]   opA,
  input  logic [VEC_W-1:0]   opB,
  input  logic [LANE_W-1:0]  memScalar,
  input  logic [MAX_VL-VEC_W-1:0] upperIn,
  output logic [MAX_VL-1:0]  dest
);
  localparam int UPPER_W = MAX_VL - VEC_W;

  logic [LANE_W-1:0]  bLane [NUM_LANES];
  logic [LANE_W-1:0]  picked;
  logic [VEC_W-1:0]   nextLow;
  logic [UPPER_W-1:0] nextUp;

  for (genvar g = 0; g < NUM_LANES; g++) begin : g_split
    assign bLane[g] = opB[g*LANE_W +: LANE_W];
  end

  assign picked = strobe.fromMem ? memScalar : bLane[strobe.srcLane];

  for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
    logic [LANE_W-1:0] merged;
    // Insert first, then mask, so a mask bit can clear the inserted lane
    assign merged = (strobe.dstLane == IDX_W'(g)) ? picked : opA[g*LANE_W +: LANE_W];
    assign nextLow[g*LANE_W +: LANE_W] = strobe.zeroMask[g] ? '0 : merged;
  end

  assign nextUp = strobe.zeroUpper ? '0 : upperIn;

  always_ff @(posedge clk) begin
    if (rst)              dest <= '0;
    else if (strobe.load) dest <= {nextUp, nextLow};
  end
endmodule

// File: rtl/vins_lane_insert.sv
module vins_lane_insert
  import vins_pkg::*;
#(
  parameter int MAX_VL = 256
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    inValid,
  input  logic [7:0]              ctrlByte,
  input  logic                    srcIsMem,
  input  logic                    extMode,
  input  logic                    vecLenBit,
  input  logic [127:0]            opA,
  input  logic [127:0]            opB,
  input  logic [31:0]             memScalar,
  input  logic [MAX_VL-129:0]     upperIn,
  output logic                    outValid,
  output logic                    illegal,
  output logic [MAX_VL-1:0]       dest
);
  dpStrobe_t strobe;

  vins_ctrl u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .inValid   (inValid),
    .ctrlByte  (ctrlByte),
    .srcIsMem  (srcIsMem),
    .extMode   (extMode),
    .vecLenBit (vecLenBit),
    .strobe    (strobe),
    .outValid  (outValid),
    .illegal   (illegal)
  );

  vins_dp #(.MAX_VL(MAX_VL)) u_dp (
    .clk       (clk),
    .rst       (rst),
    .strobe    (strobe),
    .opA       (opA),
    .opB       (opB),
    .memScalar (memScalar),
    .upperIn   (upperIn),
    .dest      (dest)
  );
endmodule

// File: rtl/vins_lane_insert_chk.sv
module vins_lane_insert_chk #(
  parameter int MAX_VL = 256
) (
  input logic                clk,
  input logic                rst,
  input logic                inValid,
  input logic [7:0]          ctrlByte,
  input logic                srcIsMem,
  input logic                extMode,
  input logic                vecLenBit,
  input logic [127:0]        opA,
  input logic [31:0]         memScalar,
  input logic [MAX_VL-129:0] upperIn,
  input logic                outValid,
  input logic                illegal,
  input logic [MAX_VL-1:0]   dest
);
  logic legalReq;
  assign legalReq = inValid && !(extMode && vecLenBit);

  p_valid_follows_r8: assert property (@(posedge clk) disable iff (rst)
    inValid |=> outValid);
  p_valid_idle_r8: assert property (@(posedge clk) disable iff (rst)
    !inValid |=> !outValid);
  p_illegal_qual_r8: assert property (@(posedge clk) disable iff (rst)
    illegal |-> outValid);
  p_illegal_hold_r7: assert property (@(posedge clk) disable iff (rst)
    (inValid && extMode && vecLenBit) |=> (illegal && $stable(dest)));
  p_idle_hold_r8: assert property (@(posedge clk) disable iff (rst)
    !inValid |=> $stable(dest));
  p_upper_keep_r5: assert property (@(posedge clk) disable iff (rst)
    (inValid && !extMode) |=> (dest[MAX_VL-1:128] == $past(upperIn)));
  p_upper_zero_r6: assert property (@(posedge clk) disable iff (rst)
    legalReq && extMode |=> (dest[MAX_VL-1:128] == '0));
  p_mem_lane0_r3: assert property (@(posedge clk) disable iff (rst)
    (legalReq && srcIsMem && ctrlByte[5:4] == 2'd0 && !ctrlByte[0])
      |=> (dest[31:0] == $past(memScalar)));

  for (genvar g = 0; g < 4; g++) begin : g_lane
    p_zero_lane_r4: assert property (@(posedge clk) disable iff (rst)
      (legalReq && ctrlByte[g]) |=> (dest[g*32 +: 32] == 32'h0));
    p_keep_lane_r2: assert property (@(posedge clk) disable iff (rst)
      (legalReq && !ctrlByte[g] && ctrlByte[5:4] != 2'(g))
        |=> (dest[g*32 +: 32] == $past(opA[g*32 +: 32])));
  end
endmodule

bind vins_lane_insert vins_lane_insert_chk #(.MAX_VL(MAX_VL)) u_chk (
  .clk(clk), .rst(rst), .inValid(inValid), .ctrlByte(ctrlByte),
  .srcIsMem(srcIsMem), .extMode(extMode), .vecLenBit(vecLenBit),
  .opA(opA), .memScalar(memScalar), .upperIn(upperIn),
  .outValid(outValid), .illegal(illegal), .dest(dest)
);

// File: tb/vins_lane_insert_tb.sv
module vins_lane_insert_tb_top;
  localparam int MAX_VL = 256;
  localparam int UW = MAX_VL - 128;

  logic clk = 1'b0;
  logic rst;
  logic inValid;
  logic [7:0] ctrlByte;
  logic srcIsMem, extMode, vecLenBit;
  logic [127:0] opA, opB;
  logic [31:0] memScalar;
  logic [UW-1:0] upperIn;
  logic outValid, illegal;
  logic [MAX_VL-1:0] dest;

  int checks = 0;
  int errors = 0;
  logic [MAX_VL-1:0] expDest;

  vins_lane_insert #(.MAX_VL(MAX_VL)) dut_i (
    .clk(clk), .rst(rst), .inValid(inValid), .ctrlByte(ctrlByte),
    .srcIsMem(srcIsMem), .extMode(extMode), .vecLenBit(vecLenBit),
    .opA(opA), .opB(opB), .memScalar(memScalar), .upperIn(upperIn),
    .outValid(outValid), .illegal(illegal), .dest(dest)
  );

  always #5 clk = ~clk;

  function automatic logic [MAX_VL-1:0] refResult(
    input logic [7:0] c, input logic m, input logic ext,
    input logic [127:0] a, input logic [127:0] b,
    input logic [31:0] s, input logic [UW-1:0] up);
    logic [31:0] v;
    logic [MAX_VL-1:0] r;
    v = m ? s : b[32*int'(c[7:6]) +: 32];
    r = '0;
    r[127:0] = a;
    r[32*int'(c[5:4]) +: 32] = v;
    for (int i = 0; i < 4; i++) if (c[i]) r[32*i +: 32] = 32'h0;
    r[MAX_VL-1:128] = ext ? '0 : up;
    return r;
  endfunction

  task automatic checkVal(input string req, input logic [MAX_VL-1:0] act,
                          input logic [MAX_VL-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  // One request; starts and ends at a falling edge, checks the response
  task automatic doOp(input string req, input logic [7:0] c, input logic m,
                      input logic ext, input logic vl, input logic [127:0] a,
                      input logic [127:0] b, input logic [31:0] s,
                      input logic [UW-1:0] up);
    logic bad;
    bad = ext && vl;
    ctrlByte = c; srcIsMem = m; extMode = ext; vecLenBit = vl;
    opA = a; opB = b; memScalar = s; upperIn = up; inValid = 1'b1;
    @(negedge clk);
    inValid = 1'b0;
    if (!bad) expDest = refResult(c, m, ext, a, b, s, up);
    checkVal({req, " outValid"}, MAX_VL'(outValid), MAX_VL'(1'b1));
    checkVal({req, " illegal"}, MAX_VL'(illegal), MAX_VL'(bad));
    checkVal({req, " dest"}, dest, expDest);
  endtask

  localparam logic [127:0] A0 = 128'hA3A3A3A3_A2A2A2A2_A1A1A1A1_A0A0A0A0;
  localparam logic [127:0] B0 = 128'hB3B3B3B3_B2B2B2B2_B1B1B1B1_B0B0B0B0;
  localparam logic [UW-1:0] UP0 = {4{32'h5EED_0001}};

  task automatic testReset();
    checkVal("R9 outValid", MAX_VL'(outValid), '0);
    checkVal("R9 illegal", MAX_VL'(illegal), '0);
    checkVal("R9 dest", dest, '0);
    expDest = '0;
  endtask

  task automatic testAllLanes();
    for (int s = 0; s < 4; s++)
      for (int d = 0; d < 4; d++)
        doOp("R1 R2 lanes", {2'(s), 2'(d), 4'h0}, 1'b0, 1'b0, 1'b0, A0, B0, 32'h0, UP0);
  endtask

  task automatic testMemSource();
    for (int s = 0; s < 4; s++)
      doOp("R3 mem", {2'(s), 2'd2, 4'h0}, 1'b1, 1'b1, 1'b0, A0, B0, 32'hCAFE_0042, UP0);
    doOp("R3 mem lane3", 8'hF0, 1'b1, 1'b0, 1'b0, A0, B0, 32'h1234_5678, UP0);
  endtask

  task automatic testZeroMask();
    doOp("R4 mask inserted", 8'b01_10_0100, 1'b0, 1'b0, 1'b0, A0, B0, 32'h0, UP0);
    doOp("R4 mask others", 8'b11_00_1010, 1'b0, 1'b0, 1'b0, A0, B0, 32'h0, UP0);
    doOp("R4 mask all", 8'b00_01_1111, 1'b0, 1'b1, 1'b0, A0, B0, 32'h0, UP0);
  endtask

  task automatic testModes();
    doOp("R5 legacy vl1", 8'b10_01_0000, 1'b0, 1'b0, 1'b1, A0, B0, 32'h0, ~UP0);
    doOp("R6 ext upper", 8'b10_11_0001, 1'b0, 1'b1, 1'b0, A0, B0, 32'h0, ~UP0);
  endtask

  task automatic testIllegal();
    doOp("R7 prior legal", 8'b00_11_0000, 1'b0, 1'b0, 1'b0, B0, A0, 32'h0, UP0);
    doOp("R7 illegal", 8'b01_00_0000, 1'b0, 1'b1, 1'b1, ~A0, ~B0, 32'h0, ~UP0);
    doOp("R7 after", 8'b01_00_0000, 1'b0, 1'b1, 1'b0, A0, B0, 32'h0, UP0);
  endtask

  task automatic testIdle();
    opA = ~A0; opB = ~B0; ctrlByte = 8'h00; upperIn = ~UP0;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      checkVal("R8 idle outValid", MAX_VL'(outValid), '0);
      checkVal("R8 idle illegal", MAX_VL'(illegal), '0);
      checkVal("R8 idle dest", dest, expDest);
    end
  endtask

  task automatic testRawBits();
    doOp("R10 nan", 8'b00_01_0000, 1'b0, 1'b0, 1'b0, A0,
         {32'h0000_0001, 32'h8000_0000, 32'hFF80_0000, 32'h7FC0_0001}, 32'h0, UP0);
    doOp("R10 denorm mem", 8'b00_10_0000, 1'b1, 1'b0, 1'b0, A0, B0, 32'h0000_0003, UP0);
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog act=hung exp=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst = 1'b1; inValid = 1'b0; ctrlByte = '0; srcIsMem = 1'b0;
    extMode = 1'b0; vecLenBit = 1'b0; opA = '0; opB = '0;
    memScalar = '0; upperIn = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    testReset();
    testAllLanes();
    testIdle();
    testMemSource();
    testZeroMask();
    testModes();
    testIllegal();
    testIdle();
    testRawBits();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule